// File: doc/BRIEF.md
# I2C Clock Divider Pair Search

This block finds the clock divider setting for an I2C master. A fixed input clock frequency is given as a parameter, and a requested SCL frequency arrives at run time. The divider chain has two stages: a linear stage with step `m` from 0 to 15 and a power-of-two stage with exponent `n` from 0 to 7. The SCL frequency for a pair is `floor(TCLK / (10 * (m+1) * 2^(n+1)))`. The block walks every pair and keeps the fastest SCL rate that does not go above the request. It reports three results: the packed divider code, the SCL frequency that code gives, and the length of one SCL period in nanoseconds with a fixed safety margin added.

A caller pulses `start` with the request on `req_hz` while `busy` is low. The search then runs by itself. It tests one candidate per clock and spends one serial division each time it finds a new best pair. After that comes a last division for the period. The results are on the outputs in the cycle where `done` pulses. They then hold until the next search ends. When no pair qualifies, the block reports the divider code the controller has after reset.

Top module: `i2c_baud_search`

## Requirements
- R1: A `start` pulse seen while `busy` is low captures `req_hz`, and `busy` is high in the following cycle. A `start` seen while `busy` is high is ignored, and so is any change on `req_hz` during a search.
- R2: Candidates are taken with `n` in the outer loop (0 to 7) and `m` in the inner loop (0 to 15). The SCL rate of a pair is floor(TCLK / (10*(m+1)*2^(n+1))). The reported code is `baud[6:3]` = m and `baud[2:0]` = n.
- R3: The reported frequency is the largest candidate rate that is at most the captured request.
- R4: When several pairs give the same best rate, the first one in search order is kept. With TCLK = 100 MHz and a request of 2,500,000, the code is 8 (m=1, n=0).
- R5: When no candidate is at or below the request (a request of 0 is one such case), `baud` is 0x44, `freq_hz` is 0 and `tick_ns` is 0.
- R6: When a pair is found, `tick_ns` = floor(1,000,000,000 / freq_hz) + 100.
- R7: `done` is high for exactly one cycle at the end of each search, and `busy` is low in that cycle.
- R8: After reset, `baud` is 0x44, `freq_hz` and `tick_ns` are 0, and `done` and `busy` are 0. The outputs change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a search; accepted only when idle |
| req_hz | input | 32 | Requested SCL frequency in Hz |
| busy | output | 1 | High while a search is running |
| done | output | 1 | One-cycle pulse when the results update |
| baud | output | 7 | Divider code {m, n} |
| freq_hz | output | 32 | SCL frequency achieved by `baud` |
| tick_ns | output | 32 | SCL period in ns plus the 100 ns margin |

## Verification
The bench uses the default parameters: a 100 MHz input clock, eight power-of-two steps and sixteen linear steps. With these values the achievable rates run from 5 MHz down to 2441 Hz, so a request of 2441 lands exactly on the slowest pair and 2440 falls just below it into the fallback. The 100 MHz clock also makes pairs with equal divisors, such as (m=1, n=0) and (m=0, n=1), so the tie rule can be seen at the ports. With an all-ones request the first candidate wins and is never beaten. Mid-range requests cause many successive improvements, and each improvement runs the shared divider.

// File: rtl/i2c_baud_pkg.sv
package i2c_baud_pkg;

    // Nanoseconds in one second, and the margin added to every SCL period.
    localparam int unsigned NS_PER_SEC = 1_000_000_000;
    localparam int unsigned TICK_PAD   = 100;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_SCAN,   // testing one candidate per cycle
        ST_QDIV,   // dividing to get the rate of a newly accepted pair
        ST_TGO,    // launching the period division
        ST_TDIV    // waiting for the period division
    } bsearch_state_e;

    typedef struct packed {
        logic fits;   // candidate rate <= request
        logic beats;  // candidate rate > best so far
    } cand_verdict_t;

    // Full divide ratio between the input clock and SCL for a pair.
    function automatic int unsigned pair_ratio(input int unsigned n, input int unsigned m);
        return 10 * (m + 1) * (2 << n);
    endfunction

endpackage

// File: rtl/i2c_baud_serdiv.sv
module i2c_baud_serdiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CNT_W = $clog2(W) + 1;

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     rem;
    logic [W-1:0]     den_q;
    logic [W:0]       trial;
    logic             ge;
    logic [W-1:0]     nxt_rem;
    logic [W-1:0]     nxt_quo;

    // Restoring division: one quotient bit per cycle, MSB first.
    always_comb begin
        trial   = {rem, quo[W-1]};
        ge      = (trial >= {1'b0, den_q});
        nxt_rem = ge ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
        nxt_quo = {quo[W-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            rem    <= '0;
            quo    <= '0;
            den_q  <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                cnt    <= '0;
                rem    <= '0;
                quo    <= num;
                den_q  <= den;
            end else if (active) begin
                rem <= nxt_rem;
                quo <= nxt_quo;
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(W - 1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2c_baud_cand.sv
module i2c_baud_cand
    import i2c_baud_pkg::*;
#(
    parameter int          FREQ_W  = 32,
    parameter int          DIV_W   = 16,
    parameter int unsigned TCLK_HZ = 100_000_000
) (
    input  logic [DIV_W-1:0]  ratio,
    input  logic [FREQ_W-1:0] req,
    input  logic [FREQ_W-1:0] best,
    output cand_verdict_t     verdict
);
    localparam int PROD_W = FREQ_W + 1 + DIV_W;
    localparam logic [PROD_W-1:0] TCLK_P = PROD_W'(TCLK_HZ);

    logic [PROD_W-1:0] ratio_p;
    logic [PROD_W-1:0] req_lim;
    logic [PROD_W-1:0] best_lim;

    // floor(T/D) <= r  <=>  T < (r+1)*D ;  floor(T/D) > b  <=>  T >= (b+1)*D
    always_comb begin
        ratio_p       = PROD_W'(ratio);
        req_lim       = (PROD_W'(req) + 1'b1) * ratio_p;
        best_lim      = (PROD_W'(best) + 1'b1) * ratio_p;
        verdict.fits  = (TCLK_P < req_lim);
        verdict.beats = (TCLK_P >= best_lim);
    end

endmodule

// File: rtl/i2c_baud_search.sv
module i2c_baud_search
    import i2c_baud_pkg::*;
#(
    parameter int          FREQ_W   = 32,
    parameter int unsigned TCLK_HZ  = 100_000_000,
    parameter int          N_CNT    = 8,
    parameter int          M_CNT    = 16,
    parameter int unsigned FALLBACK = 'h44
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start,
    input  logic [FREQ_W-1:0]                      req_hz,
    output logic                                   busy,
    output logic                                   done,
    output logic [$clog2(M_CNT)+$clog2(N_CNT)-1:0] baud,
    output logic [FREQ_W-1:0]                      freq_hz,
    output logic [FREQ_W-1:0]                      tick_ns
);
    localparam int N_W    = $clog2(N_CNT);
    localparam int M_W    = $clog2(M_CNT);
    localparam int BAUD_W = M_W + N_W;
    localparam int DIV_W  = $clog2(10 * M_CNT * (2 ** N_CNT) + 1);
    localparam logic [BAUD_W-1:0] FB_CODE = BAUD_W'(FALLBACK);

    bsearch_state_e    state;
    logic [FREQ_W-1:0] req_q;
    logic [FREQ_W-1:0] best;
    logic [BAUD_W-1:0] best_code;
    logic              found;
    logic [N_W-1:0]    n_idx;
    logic [M_W-1:0]    m_idx;
    logic              last;
    logic [DIV_W-1:0]  ratio;
    cand_verdict_t     verdict;
    logic              accept;

    logic              div_go;
    logic [FREQ_W-1:0] div_num;
    logic [FREQ_W-1:0] div_den;
    logic              div_done;
    logic [FREQ_W-1:0] div_quo;

    always_comb begin
        ratio  = DIV_W'(pair_ratio(int'(n_idx), int'(m_idx)));
        last   = (n_idx == N_W'(N_CNT - 1)) && (m_idx == M_W'(M_CNT - 1));
        accept = (state == ST_SCAN) && verdict.fits && verdict.beats;
        div_go = accept || (state == ST_TGO);
        // The divider takes TCLK/ratio during the scan and 1e9/best for the period.
        div_num = (state == ST_SCAN) ? FREQ_W'(TCLK_HZ) : FREQ_W'(NS_PER_SEC);
        div_den = (state == ST_SCAN) ? FREQ_W'(ratio)   : best;
    end

    i2c_baud_cand #(
        .FREQ_W (FREQ_W),
        .DIV_W  (DIV_W),
        .TCLK_HZ(TCLK_HZ)
    ) u_cand (
        .ratio  (ratio),
        .req    (req_q),
        .best   (best),
        .verdict(verdict)
    );

    i2c_baud_serdiv #(
        .W(FREQ_W)
    ) u_div (
        .clk (clk),
        .rst (rst),
        .go  (div_go),
        .num (div_num),
        .den (div_den),
        .done(div_done),
        .quo (div_quo)
    );

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req_q     <= '0;
            best      <= '0;
            best_code <= FB_CODE;
            found     <= 1'b0;
            n_idx     <= '0;
            m_idx     <= '0;
            done      <= 1'b0;
            baud      <= FB_CODE;
            freq_hz   <= '0;
            tick_ns   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= req_hz;
                        best  <= '0;
                        found <= 1'b0;
                        n_idx <= '0;
                        m_idx <= '0;
                        state <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (accept) begin
                        best_code <= {m_idx, n_idx};
                        state     <= ST_QDIV;
                    end else if (last) begin
                        if (found) begin
                            state <= ST_TGO;
                        end else begin
                            baud    <= FB_CODE;
                            freq_hz <= '0;
                            tick_ns <= '0;
                            done    <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end else begin
                        if (m_idx == M_W'(M_CNT - 1)) begin
                            m_idx <= '0;
                            n_idx <= n_idx + 1'b1;
                        end else begin
                            m_idx <= m_idx + 1'b1;
                        end
                    end
                end
                ST_QDIV: begin
                    if (div_done) begin
                        best  <= div_quo;
                        found <= 1'b1;
                        if (last) begin
                            state <= ST_TGO;
                        end else begin
                            if (m_idx == M_W'(M_CNT - 1)) begin
                                m_idx <= '0;
                                n_idx <= n_idx + 1'b1;
                            end else begin
                                m_idx <= m_idx + 1'b1;
                            end
                            state <= ST_SCAN;
                        end
                    end
                end
                ST_TGO: begin
                    state <= ST_TDIV;
                end
                ST_TDIV: begin
                    if (div_done) begin
                        baud    <= best_code;
                        freq_hz <= best;
                        tick_ns <= div_quo + FREQ_W'(TICK_PAD);
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_baud_search_chk.sv
module i2c_baud_search_chk #(
    parameter int          FREQ_W   = 32,
    parameter int          BAUD_W   = 7,
    parameter int unsigned FALLBACK = 'h44
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [FREQ_W-1:0] req_hz,
    input logic              busy,
    input logic              done,
    input logic [BAUD_W-1:0] baud,
    input logic [FREQ_W-1:0] freq_hz,
    input logic [FREQ_W-1:0] tick_ns
);
    logic [FREQ_W-1:0] req_seen;

    always_ff @(posedge clk) begin
        if (rst) req_seen <= '0;
        else if (start && !busy) req_seen <= req_hz;
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);                                          // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                     // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                     // R7
    AST_FREQ_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> (freq_hz <= req_seen));                                     // R3
    AST_FALLBACK_CODE: assert property (@(posedge clk) disable iff (rst)
        (done && freq_hz == '0) |-> (baud == BAUD_W'(FALLBACK) && tick_ns == '0)); // R5
    AST_TICK_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (done && freq_hz != '0) |-> (tick_ns > FREQ_W'(100)));               // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(baud) && $stable(freq_hz) && $stable(tick_ns)));  // R8

endmodule

bind i2c_baud_search i2c_baud_search_chk #(
    .FREQ_W  (FREQ_W),
    .BAUD_W  (BAUD_W),
    .FALLBACK(FALLBACK)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .req_hz (req_hz),
    .busy   (busy),
    .done   (done),
    .baud   (baud),
    .freq_hz(freq_hz),
    .tick_ns(tick_ns)
);

// File: tb/i2c_baud_search_bench.sv
module i2c_baud_search_bench;
    localparam int CLK_PERIOD = 10;
    localparam longint TCLK   = 100_000_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] req_hz = '0;
    logic        busy;
    logic        done;
    logic [6:0]  baud;
    logic [31:0] freq_hz;
    logic [31:0] tick_ns;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_baud_search u_i2c_baud_search (
        .clk(clk), .rst(rst), .start(start), .req_hz(req_hz),
        .busy(busy), .done(done), .baud(baud), .freq_hz(freq_hz), .tick_ns(tick_ns)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Independent reference: plain exhaustive search with true division.
    task automatic model(input longint req, output longint eb, output longint ef, output longint et);
        longint best = 0;
        eb = 'h44;
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 16; m++) begin
                longint f = TCLK / (10 * (m + 1) * (longint'(2) << n));
                if (f <= req && f > best) begin
                    best = f;
                    eb = m * 8 + n;
                end
            end
        end
        ef = best;
        et = (best == 0) ? 0 : (1_000_000_000 / best) + 100;
    endtask

    // Launch a search and wait for done; outputs are sampled at the negedge where done is high.
    task automatic launch(input logic [31:0] req, input string tag);
        int wait_n = 0;
        @(negedge clk);
        req_hz = req;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R1 busy after start"}, busy, 1);
        while (!done && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        chk({tag, " R7 done seen"}, done, 1);
        chk({tag, " R7 busy low at done"}, busy, 0);
    endtask

    task automatic t_expect(input logic [31:0] req, input string tag);
        longint eb, ef, et;
        model(req, eb, ef, et);
        launch(req, tag);
        chk({tag, " R2 R3 baud"}, baud, eb);
        chk({tag, " R3 freq"}, freq_hz, ef);
        chk({tag, " R6 tick"}, tick_ns, et);
        @(negedge clk);
        chk({tag, " R7 single pulse"}, done, 0);
    endtask

    task automatic t_reset_state();
        chk("R8 reset baud", baud, 'h44);
        chk("R8 reset freq", freq_hz, 0);
        chk("R8 reset tick", tick_ns, 0);
        chk("R8 reset done", done, 0);
        chk("R8 reset busy", busy, 0);
    endtask

    task automatic t_fastest();
        t_expect(32'hFFFF_FFFF, "max request");
        chk("R2 max request code", baud, 0);
        chk("R3 max request freq", freq_hz, 5_000_000);
        chk("R6 max request tick", tick_ns, 300);
    endtask

    task automatic t_tie();
        t_expect(32'd2_500_000, "tie");
        chk("R4 earliest pair kept", baud, 8);
        chk("R4 tie freq", freq_hz, 2_500_000);
        chk("R6 tie tick", tick_ns, 500);
    endtask

    task automatic t_slowest();
        t_expect(32'd2441, "slowest");
        chk("R2 slowest code m=15 n=7", baud, 'h7F);
        chk("R6 slowest tick", tick_ns, 1_000_000_000 / 2441 + 100);
    endtask

    task automatic t_fallback();
        t_expect(32'd2440, "below range");
        chk("R5 below range code", baud, 'h44);
        chk("R5 below range freq", freq_hz, 0);
        t_expect(32'd0, "zero request");
        chk("R5 zero request code", baud, 'h44);
        chk("R5 zero request tick", tick_ns, 0);
    endtask

    task automatic t_busy_ignore();
        longint eb, ef, et;
        int wait_n = 0;
        model(100_000, eb, ef, et);
        @(negedge clk);
        req_hz = 100_000;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        req_hz = 3_000_000;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        chk("R1 ignored start: done", done, 1);
        chk("R1 ignored start: baud", baud, eb);
        chk("R1 ignored start: freq", freq_hz, ef);
        @(negedge clk);
        chk("R1 no second search", busy, 0);
    endtask

    task automatic t_hold();
        logic [6:0]  b0 = baud;
        logic [31:0] f0 = freq_hz;
        logic [31:0] k0 = tick_ns;
        req_hz = 1234;
        repeat (20) @(negedge clk);
        chk("R8 baud held", baud, b0);
        chk("R8 freq held", freq_hz, f0);
        chk("R8 tick held", tick_ns, k0);
        chk("R8 stays idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_fastest();
        t_tie();
        t_expect(32'd100_000, "100k");
        t_expect(32'd400_000, "400k");
        t_expect(32'd1_000_000, "1M");
        t_slowest();
        t_fallback();
        t_busy_ignore();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule